// File: doc/BRIEF.md
# Time-Multiplexed Integrate-Leak-Fire Neuron Array

This block keeps the membrane state of a bank of digital spiking neurons, 256 by default, in a single register array. One shared arithmetic path serves the whole bank. While the block is idle, it accepts one integrate event per cycle. Each event names a neuron and an axon type. The neuron's potential then moves by the signed weight that the neuron holds for that type, either exactly or by a single unit chosen by a pseudo-random draw. The crossbar that produces these events sits upstream, and the spike network sits downstream.

A tick command starts a sweep over every neuron in ascending index order, one neuron per cycle. The sweep first applies the neuron's leak, which is also exact or stochastic. It then compares the result with the neuron's threshold. A neuron above its threshold is loaded with its reset value and emits a spike that carries the neuron's own destination core and axon. All random draws come from one seedable 32-bit LFSR, consumed in a fixed order, so a run repeats exactly from a given seed.

The controller has three states. IDLE accepts events and ticks. SWEEP visits one neuron per cycle. DONE is a one-cycle end marker. The transitions are START (IDLE to SWEEP on tick), STEP (SWEEP to SWEEP while neurons remain), LAST (SWEEP to DONE after the highest index) and RETURN (DONE to IDLE).

Top module: `ilf_neuron_array`

## Requirements
- R1: After reset every potential and every configuration field is zero, ev_ready is 1, spk_valid and sweep_done are 0, and the LFSR state is 1.
- R2: An event accepted in IDLE for a type whose stochastic bit is clear adds that type's signed weight to the neuron's 20-bit signed potential, clamped to [-524288, 524287]. The weight for type t sits in cfg_weights[t*9 +: 9], and its stochastic flag is cfg_wstoch[t].
- R3: For a type whose stochastic bit is set, the draw is the low 8 bits of the LFSR state. The potential moves by +1 (positive weight) or -1 (negative weight) when the weight's magnitude is greater than the draw, and does not move otherwise. The LFSR advances once after each stochastic decision and at no other time.
- R4: Each neuron's leak is applied exactly once per sweep, before its threshold compare. It adds the signed leak with the same clamp when cfg_lstoch is 0, and applies the rule of R3 to the leak magnitude when cfg_lstoch is 1.
- R5: A neuron whose leaked potential is strictly greater than its threshold is set to its reset value. It emits one spike that carries spk_src (its index), spk_core and spk_axon. The spike appears one cycle after that neuron's sweep cycle, and spikes come out in ascending index order.
- R6: A tick accepted in IDLE (START) gives exactly 256 SWEEP cycles and then one DONE cycle with sweep_done high. ev_ready is low through SWEEP and DONE, and events presented then have no effect.
- R7: The LFSR shifts right and XORs 0x80200003 into the state when the bit shifted out is 1. A seed write loads seed_val, or 1 when seed_val is zero, and takes precedence over an advance.
- R8: A configuration write replaces every field of the addressed neuron and leaves its potential unchanged.
- R9: An event and a tick in the same IDLE cycle are both taken, and the event is integrated before that sweep reads the neuron.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write all fields of neuron cfg_idx |
| cfg_idx | input | 8 | Neuron to configure |
| cfg_weights | input | 36 | Four signed 9-bit weights, type t at bits t*9 |
| cfg_wstoch | input | 4 | Per-type stochastic weight enable |
| cfg_leak | input | 9 | Signed leak |
| cfg_lstoch | input | 1 | Stochastic leak enable |
| cfg_thresh | input | 20 | Signed firing threshold |
| cfg_reset | input | 20 | Signed post-fire potential |
| cfg_core | input | 16 | Destination core of spikes |
| cfg_axon | input | 8 | Destination axon of spikes |
| seed_we | input | 1 | Load LFSR seed |
| seed_val | input | 32 | Seed value |
| ev_valid | input | 1 | Integrate event present |
| ev_idx | input | 8 | Target neuron of the event |
| ev_type | input | 2 | Axon type of the event |
| ev_ready | output | 1 | High in IDLE, where events and ticks are taken |
| tick | input | 1 | Start a leak-and-fire sweep |
| sweep_done | output | 1 | High in the DONE cycle |
| spk_valid | output | 1 | Spike present |
| spk_src | output | 8 | Index of the firing neuron |
| spk_core | output | 16 | Destination core |
| spk_axon | output | 8 | Destination axon |

## Verification
On every cycle, the assertions check the controller's shape. A sweep lasts exactly one cycle per neuron, DONE is a single cycle followed by IDLE, a tick in IDLE always leaves IDLE, spikes appear only in the cycle after a busy cycle, and the LFSR never reaches the all-zero state. The bench's directed scenarios are needed for the arithmetic and the order of random draws. These cover weight and leak values, saturation at both ends, the strict threshold, reset values, spike addresses, the seeded stochastic sequence, the zero-seed substitution, events ignored during a sweep, and an event that arrives together with a tick.

// File: rtl/ilf_pkg.sv
package ilf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DONE  = 2'd2
    } ilf_state_e;

    localparam int unsigned DEF_NEURONS = 256;
    localparam int unsigned DEF_POT_W   = 20;
    localparam int unsigned DEF_WT_W    = 9;
    localparam int unsigned DEF_TYPES   = 4;
    localparam int unsigned DEF_CORE_W  = 16;
    localparam int unsigned DEF_AXON_W  = 8;
    localparam int unsigned DEF_RAND_W  = 8;
    localparam int unsigned DEF_LFSR_W  = 32;
    localparam logic [31:0] DEF_LFSR_MASK = 32'h8020_0003;
endpackage

// File: rtl/ilf_lfsr.sv
module ilf_lfsr #(
    parameter int unsigned W      = ilf_pkg::DEF_LFSR_W,
    parameter int unsigned RAND_W = ilf_pkg::DEF_RAND_W,
    parameter logic [W-1:0] MASK  = ilf_pkg::DEF_LFSR_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [W-1:0]      seed,
    input  logic              advance,
    output logic [RAND_W-1:0] draw,
    output logic [W-1:0]      state_o
);
    logic [W-1:0] st_q;
    logic [W-1:0] st_step;

    // Galois right-shift form: feedback mask applied when bit 0 leaves
    always_comb begin
        st_step = (st_q >> 1) ^ (st_q[0] ? MASK : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= W'(1);
        end else if (load) begin
            st_q <= (seed == '0) ? W'(1) : seed;
        end else if (advance) begin
            st_q <= st_step;
        end
    end

    assign draw    = st_q[RAND_W-1:0];
    assign state_o = st_q;
endmodule

// File: rtl/ilf_cfg_store.sv
module ilf_cfg_store #(
    parameter int unsigned N_NEURONS = ilf_pkg::DEF_NEURONS,
    parameter int unsigned N_TYPES   = ilf_pkg::DEF_TYPES,
    parameter int unsigned WT_W      = ilf_pkg::DEF_WT_W,
    parameter int unsigned POT_W     = ilf_pkg::DEF_POT_W,
    parameter int unsigned CORE_W    = ilf_pkg::DEF_CORE_W,
    parameter int unsigned AXON_W    = ilf_pkg::DEF_AXON_W,
    localparam int unsigned IDX_W    = $clog2(N_NEURONS),
    localparam int unsigned WVEC_W   = N_TYPES * WT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WVEC_W-1:0]       wr_weights,
    input  logic [N_TYPES-1:0]      wr_wstoch,
    input  logic signed [WT_W-1:0]  wr_leak,
    input  logic                    wr_lstoch,
    input  logic signed [POT_W-1:0] wr_thresh,
    input  logic signed [POT_W-1:0] wr_reset,
    input  logic [CORE_W-1:0]       wr_core,
    input  logic [AXON_W-1:0]       wr_axon,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WVEC_W-1:0]       rd_weights,
    output logic [N_TYPES-1:0]      rd_wstoch,
    output logic signed [WT_W-1:0]  rd_leak,
    output logic                    rd_lstoch,
    output logic signed [POT_W-1:0] rd_thresh,
    output logic signed [POT_W-1:0] rd_reset,
    output logic [CORE_W-1:0]       rd_core,
    output logic [AXON_W-1:0]       rd_axon
);
    logic [WVEC_W-1:0]  weights_m [N_NEURONS];
    logic [N_TYPES-1:0] wstoch_m  [N_NEURONS];
    logic [WT_W-1:0]    leak_m    [N_NEURONS];
    logic               lstoch_m  [N_NEURONS];
    logic [POT_W-1:0]   thresh_m  [N_NEURONS];
    logic [POT_W-1:0]   reset_m   [N_NEURONS];
    logic [CORE_W-1:0]  core_m    [N_NEURONS];
    logic [AXON_W-1:0]  axon_m    [N_NEURONS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_NEURONS); i++) begin
                weights_m[i] <= '0;
                wstoch_m[i]  <= '0;
                leak_m[i]    <= '0;
                lstoch_m[i]  <= 1'b0;
                thresh_m[i]  <= '0;
                reset_m[i]   <= '0;
                core_m[i]    <= '0;
                axon_m[i]    <= '0;
            end
        end else if (wr_en) begin
            weights_m[wr_idx] <= wr_weights;
            wstoch_m[wr_idx]  <= wr_wstoch;
            leak_m[wr_idx]    <= wr_leak;
            lstoch_m[wr_idx]  <= wr_lstoch;
            thresh_m[wr_idx]  <= wr_thresh;
            reset_m[wr_idx]   <= wr_reset;
            core_m[wr_idx]    <= wr_core;
            axon_m[wr_idx]    <= wr_axon;
        end
    end

    assign rd_weights = weights_m[rd_idx];
    assign rd_wstoch  = wstoch_m[rd_idx];
    assign rd_leak    = leak_m[rd_idx];
    assign rd_lstoch  = lstoch_m[rd_idx];
    assign rd_thresh  = thresh_m[rd_idx];
    assign rd_reset   = reset_m[rd_idx];
    assign rd_core    = core_m[rd_idx];
    assign rd_axon    = axon_m[rd_idx];
endmodule

// File: rtl/ilf_arith.sv
module ilf_arith #(
    parameter int unsigned POT_W  = ilf_pkg::DEF_POT_W,
    parameter int unsigned OP_W   = ilf_pkg::DEF_WT_W,
    parameter int unsigned RAND_W = ilf_pkg::DEF_RAND_W,
    localparam int unsigned SUM_W = POT_W + 1,
    localparam int unsigned MAG_W = OP_W + 1
) (
    input  logic signed [POT_W-1:0] pot_in,
    input  logic signed [OP_W-1:0]  operand,
    input  logic                    stochastic,
    input  logic [RAND_W-1:0]       draw,
    output logic signed [POT_W-1:0] pot_out
);
    localparam logic signed [POT_W-1:0] POT_MAX = {1'b0, {(POT_W-1){1'b1}}};
    localparam logic signed [POT_W-1:0] POT_MIN = {1'b1, {(POT_W-1){1'b0}}};

    logic [MAG_W-1:0]        magnitude;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic                    ovf;

    always_comb begin
        magnitude = operand[OP_W-1] ? (~{operand[OP_W-1], operand} + MAG_W'(1))
                                    : {1'b0, operand};
        if (!stochastic) begin
            delta = {{(SUM_W-OP_W){operand[OP_W-1]}}, operand};
        end else if (magnitude > MAG_W'(draw)) begin
            delta = operand[OP_W-1] ? -SUM_W'(1) : SUM_W'(1);
        end else begin
            delta = '0;
        end
        sum = {pot_in[POT_W-1], pot_in} + delta;
        ovf = sum[SUM_W-1] ^ sum[SUM_W-2];
        if (ovf) begin
            pot_out = sum[SUM_W-1] ? POT_MIN : POT_MAX;
        end else begin
            pot_out = sum[POT_W-1:0];
        end
    end
endmodule

// File: rtl/ilf_neuron_array.sv
module ilf_neuron_array
    import ilf_pkg::*;
#(
    parameter int unsigned N_NEURONS = DEF_NEURONS,
    parameter int unsigned POT_W     = DEF_POT_W,
    parameter int unsigned WT_W      = DEF_WT_W,
    parameter int unsigned N_TYPES   = DEF_TYPES,
    parameter int unsigned CORE_W    = DEF_CORE_W,
    parameter int unsigned AXON_W    = DEF_AXON_W,
    parameter int unsigned RAND_W    = DEF_RAND_W,
    parameter int unsigned LFSR_W    = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0] LFSR_MASK = DEF_LFSR_MASK,
    localparam int unsigned IDX_W    = $clog2(N_NEURONS),
    localparam int unsigned TYPE_W   = (N_TYPES > 1) ? $clog2(N_TYPES) : 1,
    localparam int unsigned WVEC_W   = N_TYPES * WT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [WVEC_W-1:0]       cfg_weights,
    input  logic [N_TYPES-1:0]      cfg_wstoch,
    input  logic signed [WT_W-1:0]  cfg_leak,
    input  logic                    cfg_lstoch,
    input  logic signed [POT_W-1:0] cfg_thresh,
    input  logic signed [POT_W-1:0] cfg_reset,
    input  logic [CORE_W-1:0]       cfg_core,
    input  logic [AXON_W-1:0]       cfg_axon,
    input  logic                    seed_we,
    input  logic [LFSR_W-1:0]       seed_val,
    input  logic                    ev_valid,
    input  logic [IDX_W-1:0]        ev_idx,
    input  logic [TYPE_W-1:0]       ev_type,
    output logic                    ev_ready,
    input  logic                    tick,
    output logic                    sweep_done,
    output logic                    spk_valid,
    output logic [IDX_W-1:0]        spk_src,
    output logic [CORE_W-1:0]       spk_core,
    output logic [AXON_W-1:0]       spk_axon
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NEURONS - 1);

    ilf_state_e state_q, state_d;
    logic [IDX_W-1:0] sweep_idx_q;

    logic                    in_sweep;
    logic                    ev_take;
    logic [IDX_W-1:0]        rd_idx;
    logic [WVEC_W-1:0]       rd_weights;
    logic [N_TYPES-1:0]      rd_wstoch;
    logic signed [WT_W-1:0]  rd_leak;
    logic                    rd_lstoch;
    logic signed [POT_W-1:0] rd_thresh;
    logic signed [POT_W-1:0] rd_reset;
    logic [CORE_W-1:0]       rd_core;
    logic [AXON_W-1:0]       rd_axon;

    logic signed [WT_W-1:0]  op_val;
    logic                    op_stoch;
    logic signed [POT_W-1:0] pot_cur;
    logic signed [POT_W-1:0] pot_new;
    logic                    fire;
    logic [RAND_W-1:0]       rnd_draw;
    logic [LFSR_W-1:0]       lfsr_state;

    logic signed [POT_W-1:0] pot_q [N_NEURONS];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- transitions: START, STEP, LAST, RETURN ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick) state_d = ST_SWEEP;
            ST_SWEEP: if (sweep_idx_q == LAST_IDX) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  sweep_idx_q <= '0;
                ST_SWEEP: sweep_idx_q <= sweep_idx_q + IDX_W'(1);
                ST_DONE:  sweep_idx_q <= '0;
                default:  sweep_idx_q <= '0;
            endcase
        end
    end

    assign in_sweep   = (state_q == ST_SWEEP);
    assign ev_take    = (state_q == ST_IDLE) && ev_valid;
    assign ev_ready   = (state_q == ST_IDLE);
    assign sweep_done = (state_q == ST_DONE);

    // ---------------- shared datapath ----------------
    assign rd_idx = in_sweep ? sweep_idx_q : ev_idx;

    ilf_cfg_store #(
        .N_NEURONS (N_NEURONS),
        .N_TYPES   (N_TYPES),
        .WT_W      (WT_W),
        .POT_W     (POT_W),
        .CORE_W    (CORE_W),
        .AXON_W    (AXON_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_weights (cfg_weights),
        .wr_wstoch  (cfg_wstoch),
        .wr_leak    (cfg_leak),
        .wr_lstoch  (cfg_lstoch),
        .wr_thresh  (cfg_thresh),
        .wr_reset   (cfg_reset),
        .wr_core    (cfg_core),
        .wr_axon    (cfg_axon),
        .rd_idx     (rd_idx),
        .rd_weights (rd_weights),
        .rd_wstoch  (rd_wstoch),
        .rd_leak    (rd_leak),
        .rd_lstoch  (rd_lstoch),
        .rd_thresh  (rd_thresh),
        .rd_reset   (rd_reset),
        .rd_core    (rd_core),
        .rd_axon    (rd_axon)
    );

    always_comb begin
        if (in_sweep) begin
            op_val   = rd_leak;
            op_stoch = rd_lstoch;
        end else begin
            op_val   = rd_weights[ev_type*WT_W +: WT_W];
            op_stoch = rd_wstoch[ev_type];
        end
    end

    assign pot_cur = pot_q[rd_idx];

    ilf_arith #(
        .POT_W  (POT_W),
        .OP_W   (WT_W),
        .RAND_W (RAND_W)
    ) u_arith (
        .pot_in     (pot_cur),
        .operand    (op_val),
        .stochastic (op_stoch),
        .draw       (rnd_draw),
        .pot_out    (pot_new)
    );

    assign fire = in_sweep && (pot_new > rd_thresh);

    ilf_lfsr #(
        .W      (LFSR_W),
        .RAND_W (RAND_W),
        .MASK   (LFSR_MASK)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_we),
        .seed    (seed_val),
        .advance ((ev_take || in_sweep) && op_stoch),
        .draw    (rnd_draw),
        .state_o (lfsr_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_NEURONS); i++) begin
                pot_q[i] <= '0;
            end
        end else if (ev_take) begin
            pot_q[ev_idx] <= pot_new;
        end else if (in_sweep) begin
            pot_q[sweep_idx_q] <= fire ? rd_reset : pot_new;
        end
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_valid <= 1'b0;
            spk_src   <= '0;
            spk_core  <= '0;
            spk_axon  <= '0;
        end else begin
            spk_valid <= fire;
            if (fire) begin
                spk_src  <= sweep_idx_q;
                spk_core <= rd_core;
                spk_axon <= rd_axon;
            end
        end
    end
endmodule

// File: rtl/ilf_neuron_array_sva.sv
module ilf_neuron_array_sva #(
    parameter int unsigned N_NEURONS = ilf_pkg::DEF_NEURONS,
    parameter int unsigned LFSR_W    = ilf_pkg::DEF_LFSR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_ready,
    input logic              tick,
    input logic              sweep_done,
    input logic              spk_valid,
    input logic [LFSR_W-1:0] lfsr_state
);
    logic [31:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || ev_ready) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 32'd1;
        end
    end

    p_sweep_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (busy_cnt == 32'(N_NEURONS)));

    p_done_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> (ev_ready && !sweep_done));

    p_tick_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ready && tick) |=> !ev_ready);

    p_spike_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spk_valid |-> !$past(ev_ready));

    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);
endmodule

bind ilf_neuron_array ilf_neuron_array_sva #(
    .N_NEURONS (N_NEURONS),
    .LFSR_W    (LFSR_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_ready   (ev_ready),
    .tick       (tick),
    .sweep_done (sweep_done),
    .spk_valid  (spk_valid),
    .lfsr_state (lfsr_state)
);

// File: tb/ilf_neuron_array_bench.sv
module ilf_neuron_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NN = 256;
    localparam int PMAX = 524287;
    localparam int PMIN = -524288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [35:0] cfg_weights = '0;
    logic [3:0]  cfg_wstoch = '0;
    logic [8:0]  cfg_leak = '0;
    logic        cfg_lstoch = 1'b0;
    logic [19:0] cfg_thresh = '0;
    logic [19:0] cfg_reset = '0;
    logic [15:0] cfg_core = '0;
    logic [7:0]  cfg_axon = '0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_val = '0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_idx = '0;
    logic [1:0]  ev_type = '0;
    logic        tick = 1'b0;
    logic        ev_ready, sweep_done, spk_valid;
    logic [7:0]  spk_src;
    logic [15:0] spk_core;
    logic [7:0]  spk_axon;

    ilf_neuron_array u_ilf_neuron_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_weights(cfg_weights), .cfg_wstoch(cfg_wstoch), .cfg_leak(cfg_leak),
        .cfg_lstoch(cfg_lstoch), .cfg_thresh(cfg_thresh), .cfg_reset(cfg_reset),
        .cfg_core(cfg_core), .cfg_axon(cfg_axon), .seed_we(seed_we),
        .seed_val(seed_val), .ev_valid(ev_valid), .ev_idx(ev_idx),
        .ev_type(ev_type), .ev_ready(ev_ready), .tick(tick),
        .sweep_done(sweep_done), .spk_valid(spk_valid), .spk_src(spk_src),
        .spk_core(spk_core), .spk_axon(spk_axon)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model
    int          m_pot [NN];
    int          m_w   [NN][4];
    bit [3:0]    m_wst [NN];
    int          m_leak[NN];
    bit          m_lst [NN];
    int          m_th  [NN];
    int          m_rs  [NN];
    int          m_core[NN];
    int          m_axon[NN];
    logic [31:0] m_lfsr = 32'd1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(longint v);
        if (v > PMAX) return PMAX;
        if (v < PMIN) return PMIN;
        return int'(v);
    endfunction

    function automatic int m_apply(int pot, int op, bit st);
        int mag;
        int res;
        if (!st) return clampv(longint'(pot) + op);
        mag = (op < 0) ? -op : op;
        res = pot;
        if (mag > int'(m_lfsr[7:0])) res = clampv(longint'(pot) + ((op < 0) ? -1 : 1));
        m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h8020_0003 : 32'h0);
        return res;
    endfunction

    task automatic cfg_write(input int idx, input int w0, input int w1, input int w2, input int w3,
                             input bit [3:0] wst, input int leak, input bit lst,
                             input int th, input int rs, input int core, input int axon);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 8'(idx);
        cfg_weights = {9'(w3), 9'(w2), 9'(w1), 9'(w0)};
        cfg_wstoch = wst; cfg_leak = 9'(leak); cfg_lstoch = lst;
        cfg_thresh = 20'(th); cfg_reset = 20'(rs);
        cfg_core = 16'(core); cfg_axon = 8'(axon);
        @(negedge clk);
        cfg_we = 1'b0;
        m_w[idx][0] = w0; m_w[idx][1] = w1; m_w[idx][2] = w2; m_w[idx][3] = w3;
        m_wst[idx] = wst; m_leak[idx] = leak; m_lst[idx] = lst;
        m_th[idx] = th; m_rs[idx] = rs; m_core[idx] = core; m_axon[idx] = axon;
    endtask

    task automatic load_seed(input logic [31:0] v);
        @(negedge clk);
        seed_we = 1'b1; seed_val = v;
        @(negedge clk);
        seed_we = 1'b0;
        m_lfsr = (v == 32'd0) ? 32'd1 : v;
    endtask

    task automatic send_ev(input int idx, input int typ);
        @(negedge clk);
        ev_valid = 1'b1; ev_idx = 8'(idx); ev_type = 2'(typ);
        @(negedge clk);
        ev_valid = 1'b0;
        m_pot[idx] = m_apply(m_pot[idx], m_w[idx][typ], m_wst[idx][typ]);
    endtask

    // runs one sweep and compares every spike with the model
    task automatic run_tick(input string req, input bit with_ev, input int e_idx, input int e_typ,
                            input bit inject, input int j_idx);
        int exp_src[$];
        int got_src[$];
        int got_core[$];
        int got_axon[$];
        int cycles;
        bit busy_ok;
        if (with_ev) m_pot[e_idx] = m_apply(m_pot[e_idx], m_w[e_idx][e_typ], m_wst[e_idx][e_typ]);
        for (int i = 0; i < NN; i++) begin
            m_pot[i] = m_apply(m_pot[i], m_leak[i], m_lst[i]);
            if (m_pot[i] > m_th[i]) begin
                exp_src.push_back(i);
                m_pot[i] = m_rs[i];
            end
        end
        @(negedge clk);
        tick = 1'b1;
        if (with_ev) begin ev_valid = 1'b1; ev_idx = 8'(e_idx); ev_type = 2'(e_typ); end
        @(negedge clk);
        tick = 1'b0;
        ev_valid = inject; ev_idx = 8'(j_idx); ev_type = 2'd0;
        cycles = 1;
        busy_ok = 1'b1;
        while (1) begin
            if (ev_ready) busy_ok = 1'b0;
            if (spk_valid) begin
                got_src.push_back(int'(spk_src));
                got_core.push_back(int'(spk_core));
                got_axon.push_back(int'(spk_axon));
            end
            if (sweep_done || cycles > NN + 8) break;
            @(negedge clk);
            cycles++;
        end
        ev_valid = 1'b0;
        chk("R6", {req, " sweep length"}, cycles, NN + 1);
        chk("R6", {req, " ev_ready low while busy"}, busy_ok, 1);
        chk("R5", {req, " spike count"}, got_src.size(), exp_src.size());
        for (int k = 0; k < exp_src.size() && k < got_src.size(); k++) begin
            chk("R5", {req, " spike source"}, got_src[k], exp_src[k]);
            chk("R5", {req, " spike core"}, got_core[k], m_core[exp_src[k]]);
            chk("R5", {req, " spike axon"}, got_axon[k], m_axon[exp_src[k]]);
        end
        @(negedge clk);
        chk("R6", {req, " back to idle"}, ev_ready, 1);
        chk("R6", {req, " no trailing spike"}, spk_valid, 0);
    endtask

    task automatic t_reset();
        chk("R1", "ev_ready after reset", ev_ready, 1);
        chk("R1", "spk_valid after reset", spk_valid, 0);
        chk("R1", "sweep_done after reset", sweep_done, 0);
        run_tick("R1 zero config", 0, 0, 0, 0, 0);
    endtask

    task automatic t_integrate();
        cfg_write(3, 10, -7, 100, -256, 4'b0, 0, 0, 25, 0, 16'h1234, 8'h56);
        cfg_write(4, 10, 0, 0, 0, 4'b0, 0, 0, 20, 0, 16'h0004, 8'h04);
        cfg_write(10, 0, 0, 100, 0, 4'b0, 0, 0, 50, -5, 16'hBEEF, 8'hA1);
        cfg_write(200, 0, -7, 0, 0, 4'b0, 0, 0, -20, 0, 16'h00C8, 8'hC8);
        for (int i = 0; i < 3; i++) send_ev(3, 0);
        send_ev(4, 0); send_ev(4, 0);
        send_ev(10, 2);
        send_ev(200, 1); send_ev(200, 1);
        run_tick("R2 weights and strict threshold", 0, 0, 0, 0, 0);
        send_ev(200, 3);
        run_tick("R5 reset value persists", 0, 0, 0, 0, 0);
    endtask

    task automatic t_leak();
        cfg_write(20, 0, 0, 0, 0, 4'b0, 7, 0, 20, 0, 16'h0014, 8'h14);
        cfg_write(21, 0, 0, 0, 0, 4'b0, -3, 0, -10, 2, 16'h0015, 8'h15);
        for (int i = 0; i < 4; i++) run_tick("R4 deterministic leak", 0, 0, 0, 0, 0);
    endtask

    task automatic t_stochastic();
        load_seed(32'hACE1_2468);
        cfg_write(30, 128, -200, 5, 0, 4'b0011, 100, 1, 3, -1, 16'h001E, 8'h1E);
        cfg_write(31, 40, 0, 0, 0, 4'b0001, -60, 1, -3, 0, 16'h001F, 8'h1F);
        for (int i = 0; i < 12; i++) begin
            send_ev(30, i % 3);
            send_ev(31, 0);
        end
        for (int i = 0; i < 3; i++) run_tick("R3 R4 stochastic", 0, 0, 0, 0, 0);
    endtask

    task automatic t_seed_zero();
        load_seed(32'h0);
        cfg_write(40, 2, 0, 0, 0, 4'b0001, 0, 0, 2, 0, 16'h0028, 8'h28);
        for (int i = 0; i < 6; i++) send_ev(40, 0);
        run_tick("R7 zero seed", 0, 0, 0, 0, 0);
        load_seed(32'h0000_00FF);
        for (int i = 0; i < 6; i++) send_ev(40, 0);
        run_tick("R7 reseed", 0, 0, 0, 0, 0);
    endtask

    task automatic t_saturate();
        cfg_write(90, 255, -256, 0, 0, 4'b0, 0, 0, PMAX - 1, 0, 16'h005A, 8'h5A);
        cfg_write(91, 255, -256, 0, 0, 4'b0, 0, 0, PMIN, 0, 16'h005B, 8'h5B);
        for (int i = 0; i < 2060; i++) begin
            send_ev(90, 0);
            send_ev(91, 1);
        end
        run_tick("R2 saturation both ends", 0, 0, 0, 0, 0);
    endtask

    task automatic t_cfg_keep();
        cfg_write(50, 40, 0, 0, 0, 4'b0, 0, 0, 1000, 0, 16'h0032, 8'h32);
        for (int i = 0; i < 3; i++) send_ev(50, 0);
        run_tick("R8 below threshold", 0, 0, 0, 0, 0);
        cfg_write(50, 40, 0, 0, 0, 4'b0, 0, 0, 100, 0, 16'h5050, 8'h50);
        run_tick("R8 potential kept over rewrite", 0, 0, 0, 0, 0);
    endtask

    task automatic t_busy_ignore();
        cfg_write(60, 200, 0, 0, 0, 4'b0, 0, 0, 150, 0, 16'h003C, 8'h3C);
        run_tick("R6 events during sweep", 0, 0, 0, 1, 60);
        run_tick("R6 ignored event left no trace", 0, 0, 0, 0, 0);
        send_ev(60, 0);
        run_tick("R6 accepted event fires", 0, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        cfg_write(70, 50, 0, 0, 0, 4'b0, 0, 0, 40, 0, 16'h0046, 8'h46);
        run_tick("R9 event with tick", 1, 70, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < NN; i++) begin
            m_pot[i] = 0; m_wst[i] = '0; m_leak[i] = 0; m_lst[i] = 0;
            m_th[i] = 0; m_rs[i] = 0; m_core[i] = 0; m_axon[i] = 0;
            for (int t = 0; t < 4; t++) m_w[i][t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integrate();
        t_leak();
        t_stochastic();
        t_seed_zero();
        t_saturate();
        t_cfg_keep();
        t_busy_ignore();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule